// File: doc/BRIEF.md
# Eight-Bit Microprocessor I/O Port

This block is a byte-wide parallel port that sits between a processor data bus and a peripheral. It holds an eight-bit data register whose load source is chosen by a mode pin, a drive-enable rule that also depends on that mode, and a service-request bit that turns into an active-low interrupt when a peripheral strobes data in. Three-state drive is expressed as a data bus plus an enable, and the data bus reads zero while the enable is low.

In output mode the processor writes the port by selecting it: the register follows the input bus while the port is selected and the outputs drive all the time. In input mode a peripheral loads the register with its strobe, the outputs drive only while the processor selects the port, and the falling edge of the strobe raises the interrupt until the processor selects the port to read it.

The whole block runs on one system clock. All control pins and the input bus are registered once before use, the strobe falling edge is found by comparing the registered strobe with a copy one cycle older, and register transparency is modelled as loading on every clock edge while the chosen load term is high.

Top module: `io_port8`

## Requirements
- R1: The port counts as selected only while `sel_a_n` is 0 and `sel_b` is 1 together; the other three combinations leave it unselected.
- R2: With `mode_out` = 1 the enable `data_oe` is 1 regardless of selection, and the data register loads `data_in` on every cycle the port is selected.
- R3: With `mode_out` = 0 the enable `data_oe` is 1 only while the port is selected, and the data register loads `data_in` on every cycle `strobe` is 1.
- R4: While the chosen load term is 0 and `clear_n` is 1, the data register keeps its value whatever `data_in` does.
- R5: While `clear_n` is 0 and the load term is 0, the data register is cleared to zero; when the load term is 1 the load wins over the clear.
- R6: `data_out` equals the data register bit for bit (no inversion) while `data_oe` is 1, and is all zeros while `data_oe` is 0.
- R7: A 1-to-0 transition of `strobe` resets the service-request bit on the next edge, and this reset wins over both the clear and selection in that cycle.
- R8: The service-request bit is set (not interrupting) on every cycle in which `clear_n` is 0 or the port is selected, unless a strobe fall is acting in that cycle.
- R9: `irq_n` is 0 whenever the service-request bit is reset or the port is selected, and 1 otherwise.
- R10: A pin change reaches `data_oe` and `irq_n` after one rising clock edge, and a value loaded from `data_in` reaches `data_out` after two rising edges.
- R11: While `rst` is 1 the data register is zero, the service-request bit is set, and the registered controls take the unselected input-mode idle state, so `data_oe` = 0, `data_out` = 0 and `irq_n` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Select term that must be low to select the port |
| sel_b | input | 1 | Select term that must be high to select the port |
| mode_out | input | 1 | 1 = output mode, 0 = input mode |
| strobe | input | 1 | Peripheral load strobe; its falling edge requests service |
| clear_n | input | 1 | Active-low clear of the data register, also sets the service-request bit |
| data_in | input | DATA_W | Data to be captured |
| data_out | output | DATA_W | Register contents, zero while not enabled |
| data_oe | output | 1 | Drive enable standing in for three-state control |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench walks all eight combinations of the two selects and the mode so that a design decoding selection with the wrong polarity or applying one mode's enable rule to the other shows a wrong `data_oe` or a missing load. It clears the register while the port is selected in output mode and while the strobe is high, where a design that lets the clear win would read zero instead of the new byte. It drops the strobe while the clear is held low and samples `irq_n` in the single cycle the interrupt shows, which a design giving the clear priority never produces, and it counts edges from pin to output so that an extra or missing register stage lands the value one cycle off.

// File: rtl/io_port8_pkg.sv
package io_port8_pkg;

    localparam int unsigned PORT_W = 8;

    typedef struct packed {
        logic sel_a_n;
        logic sel_b;
        logic mode_out;
        logic strobe;
        logic clear_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        sel_a_n:  1'b1,
        sel_b:    1'b0,
        mode_out: 1'b0,
        strobe:   1'b0,
        clear_n:  1'b1
    };

    typedef enum logic {
        LOAD_FROM_STROBE = 1'b0,
        LOAD_FROM_SELECT = 1'b1
    } load_src_e;

    typedef enum logic [1:0] {
        SRQ_HOLD  = 2'd0,
        SRQ_SET   = 2'd1,
        SRQ_RESET = 2'd2
    } srq_op_e;

    function automatic logic is_selected(input ctrl_t c);
        return (!c.sel_a_n) && c.sel_b;
    endfunction

    function automatic load_src_e load_source(input ctrl_t c);
        return c.mode_out ? LOAD_FROM_SELECT : LOAD_FROM_STROBE;
    endfunction

    function automatic srq_op_e srq_decide(input logic fall, input logic set_req);
        if (fall)
            return SRQ_RESET;
        else if (set_req)
            return SRQ_SET;
        else
            return SRQ_HOLD;
    endfunction

endpackage

// File: rtl/io_port8_capture.sv
module io_port8_capture
    import io_port8_pkg::*;
#(
    parameter int unsigned WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  logic [WIDTH-1:0] data_i,
    output ctrl_t            ctrl_q,
    output logic [WIDTH-1:0] data_q,
    output logic             strobe_fall
);

    logic strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= CTRL_IDLE;
            data_q      <= '0;
            strobe_prev <= 1'b0;
        end else begin
            ctrl_q      <= ctrl_i;
            data_q      <= data_i;
            strobe_prev <= ctrl_q.strobe;
        end
    end

    assign strobe_fall = strobe_prev && !ctrl_q.strobe;

endmodule

// File: rtl/io_port8_latch.sv
module io_port8_latch #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
        else if (!clear_n)
            q <= '0;
    end

endmodule

// File: rtl/io_port8_srq.sv
module io_port8_srq
    import io_port8_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic set_req,
    output logic sr_q
);

    srq_op_e op;

    always_comb op = srq_decide(fall, set_req);

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= 1'b1;
        else begin
            case (op)
                SRQ_RESET: sr_q <= 1'b0;
                SRQ_SET:   sr_q <= 1'b1;
                default:   sr_q <= sr_q;
            endcase
        end
    end

endmodule

// File: rtl/io_port8.sv
module io_port8
    import io_port8_pkg::*;
#(
    parameter int unsigned DATA_W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              mode_out,
    input  logic              strobe,
    input  logic              clear_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              irq_n
);

    ctrl_t             ctrl_pin;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] data_q;
    logic              strobe_fall;
    logic              sel_q;
    logic              load_en;
    logic              clear_n_q;
    logic [DATA_W-1:0] latch_q;
    logic              sr_q;

    always_comb begin
        ctrl_pin.sel_a_n  = sel_a_n;
        ctrl_pin.sel_b    = sel_b;
        ctrl_pin.mode_out = mode_out;
        ctrl_pin.strobe   = strobe;
        ctrl_pin.clear_n  = clear_n;
    end

    io_port8_capture #(.WIDTH(DATA_W)) capture_i (
        .clk         (clk),
        .rst         (rst),
        .ctrl_i      (ctrl_pin),
        .data_i      (data_in),
        .ctrl_q      (ctrl_q),
        .data_q      (data_q),
        .strobe_fall (strobe_fall)
    );

    always_comb begin
        sel_q     = is_selected(ctrl_q);
        clear_n_q = ctrl_q.clear_n;
        case (load_source(ctrl_q))
            LOAD_FROM_SELECT: load_en = sel_q;
            default:          load_en = ctrl_q.strobe;
        endcase
    end

    io_port8_latch #(.WIDTH(DATA_W)) latch_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load_en),
        .clear_n (clear_n_q),
        .d       (data_q),
        .q       (latch_q)
    );

    io_port8_srq srq_i (
        .clk     (clk),
        .rst     (rst),
        .fall    (strobe_fall),
        .set_req (sel_q || !clear_n_q),
        .sr_q    (sr_q)
    );

    always_comb begin
        data_oe  = ctrl_q.mode_out || sel_q;
        data_out = data_oe ? latch_q : '0;
        irq_n    = !((!sr_q) || sel_q);
    end

endmodule

// File: rtl/io_port8_chk.sv
module io_port8_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              mode_out,
    input logic              strobe,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out,
    input logic              irq_n,
    input logic              load_en,
    input logic              clear_n_q,
    input logic              sel_q,
    input logic              strobe_fall,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] latch_q,
    input logic              sr_q
);

    logic [1:0] arm_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            arm_cnt <= 2'd0;
        else if (arm_cnt != 2'd2)
            arm_cnt <= arm_cnt + 2'd1;
    end

    p_oe_output_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (arm_cnt != 2'd0) && $past(mode_out) |-> data_oe);

    p_oe_input_mode_r3: assert property (@(posedge clk) disable iff (rst)
        (arm_cnt != 2'd0) && !$past(mode_out) && !(!$past(sel_a_n) && $past(sel_b))
        |-> !data_oe && (data_out == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load_en && clear_n_q |=> latch_q == $past(latch_q));

    p_load_wins_r5: assert property (@(posedge clk) disable iff (rst)
        load_en |=> latch_q == $past(data_q));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !load_en && !clear_n_q |=> latch_q == '0);

    p_fall_irq_r7: assert property (@(posedge clk) disable iff (rst)
        (arm_cnt == 2'd2) && $past(strobe, 2) && !$past(strobe) |=> !irq_n);

    p_fall_reset_r7: assert property (@(posedge clk) disable iff (rst)
        strobe_fall |=> !sr_q);

    p_set_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_q || !clear_n_q) && !strobe_fall |=> sr_q);

    p_select_irq_r9: assert property (@(posedge clk) disable iff (rst)
        (arm_cnt != 2'd0) && !$past(sel_a_n) && $past(sel_b) |-> !irq_n);

endmodule

bind io_port8 io_port8_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .mode_out    (mode_out),
    .strobe      (strobe),
    .data_oe     (data_oe),
    .data_out    (data_out),
    .irq_n       (irq_n),
    .load_en     (load_en),
    .clear_n_q   (clear_n_q),
    .sel_q       (sel_q),
    .strobe_fall (strobe_fall),
    .data_q      (data_q),
    .latch_q     (latch_q),
    .sr_q        (sr_q)
);

// File: tb/io_port8_tb_top.sv
`timescale 1ns/1ps
module io_port8_tb_top;

    localparam int W = 8;
    localparam int NVEC = 19;

    // fields: [22] sel_a_n [21] sel_b [20] mode_out [19] strobe [18] clear_n
    //         [17:10] data_in [9] exp oe [8:1] exp data_out [0] exp irq_n
    localparam logic [22:0] VEC [NVEC] = '{
        {5'b10001, 8'hA5, 1'b0, 8'h00, 1'b1},  // R1 unselected, input mode
        {5'b00001, 8'hA5, 1'b0, 8'h00, 1'b1},  // R1
        {5'b11001, 8'hA5, 1'b0, 8'h00, 1'b1},  // R1
        {5'b01001, 8'hA5, 1'b1, 8'h00, 1'b0},  // R3 selected, no strobe, R9
        {5'b10101, 8'h3C, 1'b1, 8'h00, 1'b1},  // R2 enable while unselected
        {5'b00101, 8'h3C, 1'b1, 8'h00, 1'b1},  // R2
        {5'b11101, 8'h3C, 1'b1, 8'h00, 1'b1},  // R2
        {5'b01101, 8'h3C, 1'b1, 8'h3C, 1'b0},  // R2 load while selected
        {5'b10101, 8'hFF, 1'b1, 8'h3C, 1'b1},  // R4 hold
        {5'b10011, 8'h5A, 1'b0, 8'h00, 1'b1},  // R3 strobe load, R6 gated
        {5'b10001, 8'h77, 1'b0, 8'h00, 1'b0},  // R7 strobe fall
        {5'b10101, 8'h77, 1'b1, 8'h5A, 1'b0},  // R4 R6 R9
        {5'b01101, 8'h77, 1'b1, 8'h77, 1'b0},  // R8 select sets
        {5'b10101, 8'h77, 1'b1, 8'h77, 1'b1},  // R8 released
        {5'b10100, 8'h77, 1'b1, 8'h00, 1'b1},  // R5 clear
        {5'b01100, 8'h99, 1'b1, 8'h99, 1'b0},  // R5 load beats clear
        {5'b10101, 8'h99, 1'b1, 8'h99, 1'b1},  // R4
        {5'b10010, 8'h42, 1'b0, 8'h00, 1'b1},  // R5 strobe load beats clear
        {5'b10101, 8'h42, 1'b1, 8'h42, 1'b0}   // R6 R7
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sel_a_n = 1'b1;
    logic         sel_b = 1'b0;
    logic         mode_out = 1'b0;
    logic         strobe = 1'b0;
    logic         clear_n = 1'b1;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] data_out;
    logic         data_oe;
    logic         irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    io_port8 #(.DATA_W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .sel_a_n  (sel_a_n),
        .sel_b    (sel_b),
        .mode_out (mode_out),
        .strobe   (strobe),
        .clear_n  (clear_n),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe),
        .irq_n    (irq_n)
    );

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check8(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] c, input logic [W-1:0] d);
        {sel_a_n, sel_b, mode_out, strobe, clear_n} = c;
        data_in = d;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check1("R11 oe in reset", data_oe, 1'b0);
        check8("R11 data in reset", data_out, 8'h00);
        check1("R11 irq in reset", irq_n, 1'b1);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            drive(VEC[v][22:18], VEC[v][17:10]);
            edges(3);
            check1($sformatf("R1 R2 R3 oe vec %0d", v), data_oe, VEC[v][9]);
            check8($sformatf("R4 R5 R6 data vec %0d", v), data_out, VEC[v][8:1]);
            check1($sformatf("R7 R8 R9 irq vec %0d", v), irq_n, VEC[v][0]);
        end

        // R11 reset mid-run with output mode held at the pins
        rst = 1'b1;
        edges(1);
        check1("R11 oe after reset", data_oe, 1'b0);
        check8("R11 data after reset", data_out, 8'h00);
        check1("R11 irq after reset", irq_n, 1'b1);
        rst = 1'b0;

        // R10 enable latency, input mode
        drive(5'b10001, 8'h00);
        edges(3);
        drive(5'b01001, 8'hC3);
        check1("R10 oe before edge", data_oe, 1'b0);
        edges(1);
        check1("R10 oe after one edge", data_oe, 1'b1);
        check1("R10 irq after one edge", irq_n, 1'b0);

        // R10 data latency, output mode
        drive(5'b01101, 8'h00);
        edges(3);
        drive(5'b10101, 8'h00);
        edges(3);
        drive(5'b01101, 8'hE7);
        edges(1);
        check8("R10 data after one edge", data_out, 8'h00);
        edges(1);
        check8("R10 data after two edges", data_out, 8'hE7);

        // R7 strobe fall beats held clear
        drive(5'b10110, 8'h00);
        edges(3);
        check1("R8 clear keeps irq high", irq_n, 1'b1);
        drive(5'b10100, 8'h00);
        edges(1);
        check1("R7 irq one edge after fall", irq_n, 1'b1);
        edges(1);
        check1("R7 irq two edges after fall", irq_n, 1'b0);
        edges(1);
        check1("R8 clear sets again", irq_n, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule